// File: doc/BRIEF.md
# Bus Write Issue Controller with Reissue and Pipelining

This block sits on the master side of a system bus and schedules write cycles taken from a queue of pending writes. The head of the queue (valid, address, data) is copied onto the bus, and a one-cycle valid strobe marks each attempt. An active-low write-ready input from the target decides whether an attempt counts. The decision uses two samples of ready: one in the attempt cycle and one taken two cycles earlier. An accepted write pops the queue. A refused write stays at the head and is driven again in the next slot.

A two-bit mode input selects the scheduling rules. Basic mode allows one attempt every four cycles. Reissue mode allows one attempt every two cycles, which doubles the write bandwidth. Pipelined mode also runs at one attempt every two cycles. It accepts one extra write in the cycle where ready has just dropped, and then stops issuing until ready has been seen asserted on two consecutive cycles.

Top module: `wr_issue_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bus_valid` and `q_pop` are 0 and `bus_addr`/`bus_data` are 0.
- R2: Ready is asserted when `wr_rdy_n` is 0. An attempt (a cycle with `bus_valid` high) is accepted only if ready is asserted in that cycle and was asserted two cycles earlier. The only exception is R6.
- R3: A refused attempt does not pop the queue. The same address and data are driven again at the next slot, which in modes 01 and 10 comes two cycles later.
- R4: In reissue mode (`mode`=01) and pipelined mode (`mode`=10), attempts are spaced exactly two cycles apart while work is pending. `bus_valid` is never high in two consecutive cycles.
- R5: In basic mode (`mode`=00, and also 11), attempts are spaced exactly four cycles apart while work is pending.
- R6: In pipelined mode only, an attempt is also accepted if ready is deasserted in the attempt cycle but was asserted two cycles earlier. This exception is used once, and then R7 applies.
- R7: After the extra acceptance of R6, `bus_valid` stays low until ready has been asserted in two consecutive cycles. The next attempt comes in the cycle after the second of those.
- R8: `q_pop` is high only in a cycle with `bus_valid` high. It is high exactly when the attempt is accepted, and the bus then carries the queue head's address and data.
- R9: When no work is pending, `bus_valid` stays low and `bus_addr`/`bus_data` keep the last values driven. If nothing has been driven since reset, they stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00/11 basic, 01 reissue, 10 pipelined |
| q_valid | input | 1 | Queue head holds a pending write |
| q_addr | input | ADDR_W | Address of the queue head |
| q_data | input | DATA_W | Data of the queue head |
| wr_rdy_n | input | 1 | Target write-ready, active low |
| bus_valid | output | 1 | Valid strobe for the address/data on the bus |
| bus_addr | output | ADDR_W | Bus address |
| bus_data | output | DATA_W | Bus data |
| q_pop | output | 1 | Removes the queue head (write accepted) |

## Verification
The assertions rely on three assumptions about the inputs:
- `mode` changes only while `rst` is high.
- The queue head stays unchanged until `q_pop` removes it.
- `q_valid` is never withdrawn while a write is pending.

If these did not hold, the reissue-spacing and address-repeat properties could not be stated at all. The stimulus keeps within them: mode changes only under reset, and the bench's queue model advances its head only in the cycle after it sees `q_pop`. The ready patterns include steady ready, a short two-cycle drop and a long drop, so both the refuse-and-reissue path and the extra pipelined acceptance are exercised.

// File: rtl/wr_issue_pkg.sv
package wr_issue_pkg;

    typedef enum logic [1:0] {
        MODE_BASIC     = 2'b00,
        MODE_REISSUE   = 2'b01,
        MODE_PIPE      = 2'b10,
        MODE_BASIC_ALT = 2'b11
    } wmode_e;

    // ready samples as seen in the current cycle
    typedef struct packed {
        logic now;   // ready in this cycle
        logic prev;  // ready one cycle back
        logic back;  // ready at the lookback distance
    } rdy_hist_t;

    // outcome of the attempt in the current cycle
    typedef struct packed {
        logic accept;
        logic extra;
        logic fail;
    } verdict_t;

    function automatic logic is_fast(input logic [1:0] m);
        return (m == MODE_REISSUE) || (m == MODE_PIPE);
    endfunction

    function automatic logic is_pipe(input logic [1:0] m);
        return m == MODE_PIPE;
    endfunction

endpackage

// File: rtl/wi_rdy_hist.sv
module wi_rdy_hist
    import wr_issue_pkg::*;
#(
    parameter int LOOKBACK = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_rdy_n,
    output rdy_hist_t hist
);
    logic [LOOKBACK:1] past_q;
    logic              rdy_now;

    assign rdy_now = ~wr_rdy_n;

    // history registers start as "not ready" after reset
    always_ff @(posedge clk) begin
        if (rst) begin
            past_q <= '0;
        end else begin
            past_q <= {past_q[LOOKBACK-1:1], rdy_now};
        end
    end

    always_comb begin
        hist.now  = rdy_now;
        hist.prev = past_q[1];
        hist.back = past_q[LOOKBACK];
    end
endmodule

// File: rtl/wi_slot_timer.sv
module wi_slot_timer
    import wr_issue_pkg::*;
#(
    parameter int BASIC_GAP = 3,
    parameter int FAST_GAP  = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       attempt,
    output logic       slot_open
);
    localparam int MAXGAP = (BASIC_GAP > FAST_GAP) ? BASIC_GAP : FAST_GAP;
    localparam int CW     = (MAXGAP < 2) ? 1 : $clog2(MAXGAP + 1);
    localparam logic [CW-1:0] BASIC_LOAD = CW'(BASIC_GAP - 1);
    localparam logic [CW-1:0] FAST_LOAD  = CW'(FAST_GAP - 1);

    logic [CW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (attempt) begin
            gap_q <= is_fast(mode) ? FAST_LOAD : BASIC_LOAD;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign slot_open = !attempt && (gap_q == '0);
endmodule

// File: rtl/wi_judge.sv
module wi_judge
    import wr_issue_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       attempt,
    input  rdy_hist_t  hist,
    output verdict_t   verdict,
    output logic       launch_block
);
    logic hold_q;
    logic release_ok;
    logic normal_ok;
    logic extra_ok;

    assign normal_ok  = attempt && hist.now && hist.back;
    assign extra_ok   = attempt && is_pipe(mode) && !hist.now && hist.back && !hold_q;
    assign release_ok = hist.now && hist.prev;

    always_comb begin
        verdict.accept = normal_ok || extra_ok;
        verdict.extra  = extra_ok;
        verdict.fail   = attempt && !(normal_ok || extra_ok);
    end

    assign launch_block = hold_q && !release_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (hold_q && release_ok) begin
            hold_q <= 1'b0;
        end else if (extra_ok) begin
            hold_q <= 1'b1;
        end
    end
endmodule

// File: rtl/wr_issue_sched.sv
module wr_issue_sched
    import wr_issue_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BASIC_GAP = 3,
    parameter int FAST_GAP  = 1,
    parameter int LOOKBACK  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              q_valid,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [DATA_W-1:0] q_data,
    input  logic              wr_rdy_n,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              q_pop
);
    rdy_hist_t         hist;
    verdict_t          verdict;
    logic              slot_open;
    logic              launch_block;
    logic              launch_any;
    logic              launch_new;
    logic              pend_q;
    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    wi_rdy_hist #(.LOOKBACK(LOOKBACK)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .wr_rdy_n (wr_rdy_n),
        .hist     (hist)
    );

    wi_slot_timer #(.BASIC_GAP(BASIC_GAP), .FAST_GAP(FAST_GAP)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .attempt   (valid_q),
        .slot_open (slot_open)
    );

    wi_judge u_judge (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .attempt      (valid_q),
        .hist         (hist),
        .verdict      (verdict),
        .launch_block (launch_block)
    );

    // a refused write is re-driven from the held copy; new work comes from the head
    assign launch_any = slot_open && !launch_block && (pend_q || q_valid);
    assign launch_new = launch_any && !pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            valid_q <= launch_any;
            if (launch_new) begin
                addr_q <= q_addr;
                data_q <= q_data;
            end
            if (verdict.fail) begin
                pend_q <= 1'b1;
            end else if (verdict.accept) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign bus_valid = valid_q;
    assign bus_addr  = addr_q;
    assign bus_data  = data_q;
    assign q_pop     = verdict.accept;
endmodule

// File: rtl/wr_issue_sched_chk.sv
module wr_issue_sched_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              wr_rdy_n,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              q_pop
);
    // R8
    pop_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        q_pop |-> bus_valid);

    // R4
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> !bus_valid);

    // R2
    pop_needs_old_ready_chk: assert property (@(posedge clk) disable iff (rst)
        q_pop |-> $past(!wr_rdy_n, 2));

    // R6
    extra_only_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        (q_pop && wr_rdy_n) |-> (mode == 2'b10));

    // R3
    reissue_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && bus_valid && !q_pop) |-> ##2 (bus_valid && bus_addr == $past(bus_addr, 2)));

    // R9
    idle_bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> $stable(bus_addr));
endmodule

bind wr_issue_sched wr_issue_sched_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .wr_rdy_n  (wr_rdy_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .q_pop     (q_pop)
);

// File: tb/wr_issue_sched_tb.sv
module wr_issue_sched_tb;
    localparam int CLK_P = 10;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int NV    = 9;

    // {mode, writes, ready per cycle, expected valid per cycle, expected pop per cycle}
    localparam logic [53:0] VEC [NV] = '{
        {2'b01, 4'd4, 16'hFFFF, 16'h02AA, 16'h02A8},  // reissue, steady ready
        {2'b00, 4'd3, 16'hFFFF, 16'h2222, 16'h2220},  // basic, steady ready
        {2'b01, 4'd3, 16'hFF9F, 16'h0AAA, 16'h0A08},  // reissue, short drop
        {2'b10, 4'd4, 16'hFF9F, 16'h0A2A, 16'h0A28},  // pipelined, short drop
        {2'b10, 4'd3, 16'hF81F, 16'h202A, 16'h2028},  // pipelined, long drop
        {2'b01, 4'd0, 16'hFFFF, 16'h0000, 16'h0000},  // empty queue
        {2'b11, 4'd2, 16'hFFFF, 16'h0222, 16'h0220},  // alternate basic code
        {2'b10, 4'd4, 16'hFFFF, 16'h02AA, 16'h02A8},  // pipelined, steady ready
        {2'b00, 4'd2, 16'hFF9F, 16'h2222, 16'h2200}   // basic, short drop: no extra
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    mode;
    logic          q_valid;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_data;
    logic          wr_rdy_n;
    logic          bus_valid;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic          q_pop;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wr_issue_sched #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .q_valid   (q_valid),
        .q_addr    (q_addr),
        .q_data    (q_data),
        .wr_rdy_n  (wr_rdy_n),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .q_pop     (q_pop)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input int s, input int i);
        return AW'(32'h100 * (s + 1) + 4 * i);
    endfunction

    function automatic logic [DW-1:0] data_of(input int s, input int i);
        return DW'(32'hD000_0000 + s * 256 + i);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        mode     = 2'b00;
        q_valid  = 1'b0;
        q_addr   = '0;
        q_data   = '0;
        wr_rdy_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1 reset state
        check(!bus_valid && !q_pop, "R1", "strobes in reset", {62'd0, bus_valid, q_pop}, 64'd0);
        check(bus_addr == '0 && bus_data == '0, "R1", "bus in reset", {bus_addr, bus_data}, 64'd0);

        for (int s = 0; s < NV; s++) begin
            logic [1:0]  vm;
            int          vn;
            logic [15:0] vr;
            logic [15:0] ev;
            logic [15:0] ep;
            logic [15:0] seen_v;
            logic [15:0] seen_p;
            int          head;
            int          badbus;
            vm = VEC[s][53:52];
            vn = int'(VEC[s][51:48]);
            vr = VEC[s][47:32];
            ev = VEC[s][31:16];
            ep = VEC[s][15:0];
            rst = 1'b1;
            mode = vm;
            q_valid = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk);
            rst    = 1'b0;
            head   = 0;
            badbus = 0;
            seen_v = '0;
            seen_p = '0;
            for (int k = 0; k < 16; k++) begin
                wr_rdy_n = ~vr[k];
                q_valid  = (head < vn);
                q_addr   = addr_of(s, head);
                q_data   = data_of(s, head);
                #1;
                seen_v[k] = bus_valid;
                seen_p[k] = q_pop;
                if (bus_valid && (bus_addr != q_addr || bus_data != q_data)) badbus++;
                @(posedge clk);
                if (seen_p[k]) head++;
                @(negedge clk);
            end
            #1;
            // R2 R4 R5 R7: attempt timing
            check(seen_v == ev, "R2/R4/R5/R7", $sformatf("valid pattern vec %0d", s), 64'(seen_v), 64'(ev));
            // R2 R6 R7: acceptance timing
            check(seen_p == ep, "R2/R6/R7", $sformatf("pop pattern vec %0d", s), 64'(seen_p), 64'(ep));
            // R3 R8: every attempt carries the queue head
            check(badbus == 0, "R3/R8", $sformatf("bus content vec %0d", s), 64'(badbus), 64'd0);
            // R9: idle bus holds the last write
            if (vn > 0) begin
                check(!bus_valid && bus_addr == addr_of(s, vn - 1) && bus_data == data_of(s, vn - 1),
                      "R9", $sformatf("idle hold vec %0d", s), 64'(bus_addr), 64'(addr_of(s, vn - 1)));
            end else begin
                check(!bus_valid && bus_addr == '0 && bus_data == '0,
                      "R9", "empty queue bus", {bus_addr, bus_data}, 64'd0);
            end
        end

        // R1: reset in the middle of an attempt
        rst  = 1'b1;
        mode = 2'b01;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst      = 1'b0;
        wr_rdy_n = 1'b0;
        q_valid  = 1'b1;
        q_addr   = 32'hCAFE_0010;
        q_data   = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(bus_valid && q_pop && bus_addr == 32'hCAFE_0010, "R8", "accepted attempt before reset",
              {62'd0, bus_valid, q_pop}, 64'd3);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        check(!bus_valid && !q_pop && bus_addr == '0 && bus_data == '0, "R1", "reset mid-run",
              {bus_addr, 30'd0, bus_valid, q_pop}, 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule